// File: doc/BRIEF.md
# Fixed-Point Escape-Time Raster Engine

This block renders one frame of escape-time values for the Mandelbrot set. A host sends one configuration beat over a valid/ready channel. The beat holds the complex start point, the horizontal and vertical step per pixel, the raster width and height, and an iteration cap. The engine then walks the raster in row-major order. For every pixel it runs the recurrence z ← z² + c in signed Q4.12 fixed point, with z starting at zero.

Each pixel stops on one of two conditions: the iteration cap, or |z|² exceeding 4.0. The pixel's iteration count is then offered on a result stream with backpressure. The engine waits for each result to be taken before it starts the next pixel. It raises a one-cycle frame-done pulse once the final pixel of the raster has been handed over, and then returns to idle, ready for the next configuration beat.

Top module: `mandel_engine`

## Requirements
- R1: `cfgReady` is high exactly while the engine is idle (no frame in progress). A configuration beat is taken on a clock edge where `cfgValid` and `cfgReady` are both high. `cfgValid` asserted while a frame is running has no effect on any result of that frame.
- R2: The engine treats coordinates as signed Q4.12 two's complement (12 fractional bits). Each pixel starts from z = 0. One iteration computes re' = (re·re >>> 12) − (im·im >>> 12) + cRe and im' = (re·im >>> 11) + cIm, where >>> is an arithmetic shift of the full-width product.
- R3: Before each iteration the engine forms (re·re >>> 12) + (im·im >>> 12). If that sum is strictly greater than 16384 (4.0), the pixel ends and reports the number of iterations done so far. A magnitude of exactly 4.0 does not end the pixel. z is held wide enough that it never wraps.
- R4: When the count of iterations done equals the 16-bit cap, the pixel ends and reports the cap. No reported count exceeds the cap. The cap test is made before the divergence test.
- R5: A cap of zero makes every pixel of the frame report 0.
- R6: Pixels are emitted row by row, left to right. Within a row, cRe grows by the horizontal step per pixel. At the start of each new row, cRe returns to the start value and cIm grows by the vertical step. Both parts of c wrap modulo 2^16. Width and height must be at least 1.
- R7: While `resValid` is high and `resReady` is low, `resValid` stays high and `resCount` stays unchanged.
- R8: `frameDone` is high for exactly one cycle: the cycle after the handshake of the frame's last result. In that same cycle `resValid` is low and `cfgReady` is high.
- R9: One iteration takes one clock. For the first pixel of a frame, whose count is n, `resValid` first reads high n+1 rising edges after the edge that accepted the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration beat offered |
| cfgReady | output | 1 | Engine idle, beat can be taken |
| cfgStartRe | input | DATA_W | Real part of c at the first pixel (Q4.12) |
| cfgStartIm | input | DATA_W | Imaginary part of c at the first pixel (Q4.12) |
| cfgStepRe | input | DATA_W | Real step per pixel along a row (Q4.12) |
| cfgStepIm | input | DATA_W | Imaginary step per row (Q4.12) |
| cfgWidth | input | DIM_W | Pixels per row |
| cfgHeight | input | DIM_W | Rows per frame |
| cfgMaxIter | input | ITER_W | Iteration cap |
| resValid | output | 1 | Result count offered |
| resReady | input | 1 | Consumer takes the result |
| resCount | output | ITER_W | Iterations done for the current pixel |
| frameDone | output | 1 | One-cycle pulse after the last result |

## Verification
The bench builds the engine with its default parameters: 16-bit Q4.12 coordinates, 16-bit counts and 10-bit dimensions.

With 12 fractional bits, the exact boundaries fall on simple values. c = 2.0 and c = −2.0 hit |z|² = 4.0 exactly, which tests the strict compare. c = 3.0 escapes after one step, and c = 0 runs to the cap.

A start of 7.0 with a step of 0.75 pushes cRe across the 16-bit wrap within a few pixels. Small widths and heights keep many frames within the cycle budget, so that random caps from 0 to 40, random stalls and row turns are all reached many times.

// File: rtl/mandel_pkg.sv
package mandel_pkg;

  // strobes from the sequencer to the arithmetic datapath
  typedef struct packed {
    logic loadCfg;   // take a configuration beat, c <= start, z <= 0
    logic stepZ;     // perform one z <= z^2 + c iteration
    logic nextCol;   // move to the next pixel in the same row
    logic nextRow;   // move to the first pixel of the next row
  } dpCtrl_t;

endpackage

// File: rtl/mandel_datapath.sv
module mandel_datapath
  import mandel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] cfgStartRe,
  input  logic [DATA_W-1:0] cfgStartIm,
  input  logic [DATA_W-1:0] cfgStepRe,
  input  logic [DATA_W-1:0] cfgStepIm,
  output logic              escape
);

  // z carries two guard bits so z^2 + c cannot wrap before the escape test
  localparam int ZW = DATA_W + 2;
  localparam int PW = 2 * ZW;
  localparam logic signed [PW:0] ESC_LIMIT = (PW+1)'(4) <<< FRAC_W;

  logic signed [DATA_W-1:0] startRe, stepRe, stepIm;
  logic signed [DATA_W-1:0] cRe, cIm;
  logic signed [ZW-1:0]     zRe, zIm;

  logic signed [PW-1:0] zReW, zImW;
  logic signed [PW-1:0] prodRR, prodII, prodRI;
  logic signed [PW-1:0] sqRe, sqIm;
  logic signed [PW:0]   magSq;
  logic signed [PW-1:0] nextReFull, nextImFull;
  logic signed [ZW-1:0] nextRe, nextIm;

  always_comb begin
    zReW       = PW'(zRe);
    zImW       = PW'(zIm);
    prodRR     = zReW * zReW;
    prodII     = zImW * zImW;
    prodRI     = zReW * zImW;
    sqRe       = prodRR >>> FRAC_W;
    sqIm       = prodII >>> FRAC_W;
    magSq      = (PW+1)'(sqRe) + (PW+1)'(sqIm);
    escape     = magSq > ESC_LIMIT;
    nextReFull = sqRe - sqIm + PW'(cRe);
    nextImFull = (prodRI >>> (FRAC_W - 1)) + PW'(cIm);
    nextRe     = ZW'(nextReFull);
    nextIm     = ZW'(nextImFull);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startRe <= '0;
      stepRe  <= '0;
      stepIm  <= '0;
      cRe     <= '0;
      cIm     <= '0;
      zRe     <= '0;
      zIm     <= '0;
    end else begin
      if (ctrl.loadCfg) begin
        startRe <= $signed(cfgStartRe);
        stepRe  <= $signed(cfgStepRe);
        stepIm  <= $signed(cfgStepIm);
        cRe     <= $signed(cfgStartRe);
        cIm     <= $signed(cfgStartIm);
        zRe     <= '0;
        zIm     <= '0;
      end else if (ctrl.stepZ) begin
        zRe <= nextRe;
        zIm <= nextIm;
      end else if (ctrl.nextCol) begin
        cRe <= cRe + stepRe;
        zRe <= '0;
        zIm <= '0;
      end else if (ctrl.nextRow) begin
        cRe <= startRe;
        cIm <= cIm + stepIm;
        zRe <= '0;
        zIm <= '0;
      end
    end
  end

  // an iteration is only taken on a z that has not yet escaped
  assert_step_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepZ |-> !escape);

  // the truncated update must equal the full-width one (no wrap)
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stepZ |-> (PW'(nextRe) == nextReFull) && (PW'(nextIm) == nextImFull));

  // a fresh pixel always starts from z = 0
  assert_z_cleared_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.nextCol || ctrl.nextRow || ctrl.loadCfg) |=> (zRe == '0) && (zIm == '0));

endmodule

// File: rtl/mandel_ctrl.sv
module mandel_ctrl
  import mandel_pkg::*;
#(
  parameter int ITER_W = 16,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  output logic              cfgReady,
  input  logic [DIM_W-1:0]  cfgWidth,
  input  logic [DIM_W-1:0]  cfgHeight,
  input  logic [ITER_W-1:0] cfgMaxIter,
  input  logic              escape,
  output logic              resValid,
  input  logic              resReady,
  output logic [ITER_W-1:0] resCount,
  output logic              frameDone,
  output dpCtrl_t           ctrl
);

  typedef enum logic [1:0] {S_IDLE, S_ITER, S_EMIT} state_t;

  state_t            state;
  logic [ITER_W-1:0] iterQ, maxIterQ;
  logic [DIM_W-1:0]  widthQ, heightQ, colQ, rowQ;
  logic              doneQ;

  logic hitCap, lastCol, lastRow, accept, handshake;

  always_comb begin
    hitCap    = iterQ == maxIterQ;
    lastCol   = colQ == (widthQ - DIM_W'(1));
    lastRow   = rowQ == (heightQ - DIM_W'(1));
    accept    = (state == S_IDLE) && cfgValid;
    handshake = (state == S_EMIT) && resReady;

    ctrl.loadCfg = accept;
    ctrl.stepZ   = (state == S_ITER) && !hitCap && !escape;
    ctrl.nextCol = handshake && !lastCol;
    ctrl.nextRow = handshake && lastCol && !lastRow;

    cfgReady  = state == S_IDLE;
    resValid  = state == S_EMIT;
    resCount  = iterQ;
    frameDone = doneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      iterQ    <= '0;
      maxIterQ <= '0;
      widthQ   <= '0;
      heightQ  <= '0;
      colQ     <= '0;
      rowQ     <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          maxIterQ <= cfgMaxIter;
          widthQ   <= cfgWidth;
          heightQ  <= cfgHeight;
          colQ     <= '0;
          rowQ     <= '0;
          iterQ    <= '0;
          state    <= S_ITER;
        end
        S_ITER: begin
          if (hitCap || escape) state <= S_EMIT;
          else                  iterQ <= iterQ + ITER_W'(1);
        end
        S_EMIT: if (handshake) begin
          iterQ <= '0;
          if (!lastCol) begin
            colQ  <= colQ + DIM_W'(1);
            state <= S_ITER;
          end else if (!lastRow) begin
            colQ  <= '0;
            rowQ  <= rowQ + DIM_W'(1);
            state <= S_ITER;
          end else begin
            doneQ <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_cfg_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgReady |-> !resValid);

  assert_cap_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resCount <= maxIterQ));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resCount)));

  assert_done_after_hs_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameDone) |-> $past(resValid && resReady));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

endmodule

// File: rtl/mandel_engine.sv
module mandel_engine
  import mandel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12,
  parameter int ITER_W = 16,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgValid,
  output logic              cfgReady,
  input  logic [DATA_W-1:0] cfgStartRe,
  input  logic [DATA_W-1:0] cfgStartIm,
  input  logic [DATA_W-1:0] cfgStepRe,
  input  logic [DATA_W-1:0] cfgStepIm,
  input  logic [DIM_W-1:0]  cfgWidth,
  input  logic [DIM_W-1:0]  cfgHeight,
  input  logic [ITER_W-1:0] cfgMaxIter,
  output logic              resValid,
  input  logic              resReady,
  output logic [ITER_W-1:0] resCount,
  output logic              frameDone
);

  dpCtrl_t ctrl;
  logic    escape;

  mandel_ctrl #(.ITER_W(ITER_W), .DIM_W(DIM_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgReady(cfgReady),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgMaxIter(cfgMaxIter),
    .escape(escape),
    .resValid(resValid), .resReady(resReady), .resCount(resCount),
    .frameDone(frameDone), .ctrl(ctrl)
  );

  mandel_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .cfgStartRe(cfgStartRe), .cfgStartIm(cfgStartIm),
    .cfgStepRe(cfgStepRe), .cfgStepIm(cfgStepIm),
    .escape(escape)
  );

endmodule

// File: tb/mandel_engine_tb.sv
module mandel_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgValid = 1'b0;
  logic        cfgReady;
  logic [15:0] cfgStartRe = '0, cfgStartIm = '0, cfgStepRe = '0, cfgStepIm = '0;
  logic [9:0]  cfgWidth = '0, cfgHeight = '0;
  logic [15:0] cfgMaxIter = '0;
  logic        resValid;
  logic        resReady = 1'b0;
  logic [15:0] resCount;
  logic        frameDone;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  mandel_engine u_dut (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgReady(cfgReady),
    .cfgStartRe(cfgStartRe), .cfgStartIm(cfgStartIm),
    .cfgStepRe(cfgStepRe), .cfgStepIm(cfgStepIm),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgMaxIter(cfgMaxIter),
    .resValid(resValid), .resReady(resReady), .resCount(resCount),
    .frameDone(frameDone)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // escape-time reference in Q4.12
  function automatic int unsigned refCount(input logic signed [15:0] cr,
                                           input logic signed [15:0] ci,
                                           input int unsigned maxIt);
    longint zr = 0, zi = 0, sr, si, nzr;
    for (int unsigned it = 0; it < maxIt; it++) begin
      sr = (zr * zr) >>> 12;
      si = (zi * zi) >>> 12;
      if (sr + si > 16384) return it;
      nzr = sr - si + longint'(cr);
      zi  = ((zr * zi) >>> 11) + longint'(ci);
      zr  = nzr;
    end
    return maxIt;
  endfunction

  task automatic runFrame(input logic signed [15:0] sRe, input logic signed [15:0] sIm,
                          input logic signed [15:0] dx, input logic signed [15:0] dy,
                          input int w, input int h, input int unsigned mx,
                          input bit stall, input bit junkCfg, input string req);
    logic signed [15:0] cr, ci;
    int unsigned expCnt;
    int waitCnt;
    bit seen;
    logic [15:0] lastCnt;
    check(cfgReady == 1'b1, "R1", cfgReady, 1);
    cfgValid = 1'b1;
    cfgStartRe = sRe; cfgStartIm = sIm; cfgStepRe = dx; cfgStepIm = dy;
    cfgWidth = 10'(w); cfgHeight = 10'(h); cfgMaxIter = 16'(mx);
    @(posedge clk); #1;
    cfgValid = junkCfg;
    if (junkCfg) begin
      cfgStartRe = 16'($urandom); cfgStartIm = 16'($urandom);
      cfgStepRe = 16'($urandom); cfgMaxIter = 16'($urandom % 5);
    end
    cr = sRe; ci = sIm;
    for (int row = 0; row < h; row++) begin
      for (int col = 0; col < w; col++) begin
        expCnt = refCount(cr, ci, mx);
        waitCnt = 0; seen = 0; lastCnt = '0;
        forever begin
          @(posedge clk); #1;
          waitCnt++;
          resReady = stall ? (($urandom % 3) != 0) : 1'b1;
          #1;
          if (resValid) begin
            if (!seen && row == 0 && col == 0)
              check(waitCnt == int'(expCnt) + 1, "R9", waitCnt, expCnt + 1);
            if (seen) check(resCount == lastCnt, "R7", resCount, lastCnt);
            seen = 1; lastCnt = resCount;
            if (resReady) begin
              check(resCount == 16'(expCnt), req, resCount, expCnt);
              check(cfgReady == 1'b0, "R1", cfgReady, 0);
              break;
            end
          end
          if (waitCnt > 5000) begin
            check(1'b0, "R9", waitCnt, expCnt + 1);
            break;
          end
        end
        if (col == w - 1) begin cr = sRe; ci = ci + dy; end
        else cr = cr + dx;
      end
    end
    @(posedge clk); #1;
    resReady = 1'b0; cfgValid = 1'b0;
    #1;
    check(frameDone == 1'b1, "R8", frameDone, 1);
    check(resValid == 1'b0, "R8", resValid, 0);
    check(cfgReady == 1'b1, "R8", cfgReady, 1);
    @(posedge clk); #2;
    check(frameDone == 1'b0, "R8", frameDone, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    check(cfgReady == 1'b1, "R1 reset", cfgReady, 1);
    check(resValid == 1'b0, "R7 reset", resValid, 0);
    check(frameDone == 1'b0, "R8 reset", frameDone, 0);

    runFrame(16'sh0000, 16'sh0000, 0, 0, 1, 1, 20, 0, 0, "R4");      // cap reached
    runFrame(16'sh3000, 16'sh0000, 0, 0, 1, 1, 50, 0, 0, "R3");      // c=3.0 -> 1
    runFrame(16'sh2000, 16'sh0000, 0, 0, 1, 1, 50, 0, 0, "R3");      // |z|^2 = 4.0 exactly
    runFrame(-16'sh2000, 16'sh0000, 0, 0, 1, 1, 30, 0, 0, "R3");     // stays at 4.0 -> cap
    runFrame(-16'sh2000, -16'sh1000, 16'sh0400, 16'sh0400, 4, 3, 0, 1, 0, "R5");
    runFrame(16'sh7000, 16'shF800, 16'sh0C00, 16'sh0300, 5, 2, 10, 0, 0, "R6");  // cRe wraps
    runFrame(-16'sh2000, -16'sh1200, 16'sh0300, 16'sh0400, 6, 4, 25, 1, 1, "R1");
    for (int f = 0; f < 8; f++) begin
      runFrame(16'(-16'sh2800 + int'($urandom % 16'h3000)),
               16'(-16'sh1800 + int'($urandom % 16'h3000)),
               16'($urandom % 16'h0600), 16'($urandom % 16'h0600),
               1 + int'($urandom % 6), 1 + int'($urandom % 5),
               $urandom % 41, bit'($urandom % 2), 0, "R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule